// File: doc/BRIEF.md
# LCD Row-Scan Timing Generator

This block turns a base oscillator clock into the timing set a dot-matrix STN row driver and its column drivers share. As timing owner it drives two non-overlapping column-driver clock phases, a line clock, a frame-start marker and a frame polarity signal. An optional pre-divide by two halves the base clock, and a two-bit duty code sets the panel height. The line length in column-clock cycles shrinks as the panel grows, so the frame length stays the same for every duty code.

As a follower it drives nothing. Each timing output has its own enable, which a pad wrapper uses to tri-state the pin. The line clock and polarity from the external owner are passed through to the local scan outputs, which feed the row shift register. Those scan outputs carry the block's own line clock and polarity when it is the owner.

Top module: `lcd_scan_timing`

## Requirements
- R1: With `master_i` high, the state right after a synchronous active-low reset is: frame marker high, polarity low, line clock high, phase 1 high and phase 2 low.
- R2: Phase 1 is high for the first half of each column-clock period and phase 2 for the second half. The period is 2 base cycles with `fdiv_i`=0 and 4 base cycles with `fdiv_i`=1.
- R3: Phase 1 and phase 2 are never high in the same cycle.
- R4: The lines per frame follow `duty_i` (bit 1 is the first duty select): 2'b11 gives 128, 2'b10 gives 96, 2'b01 gives 64 and 2'b00 gives 48. The frame marker is high for the whole of line 0 and low otherwise.
- R5: A line lasts 24, 32, 48 or 64 column-clock periods for 128, 96, 64 or 48 lines. The line clock is high for the first half of each line.
- R6: Polarity starts low and toggles exactly where a new frame begins, on the cycle in which the frame marker rises.
- R7: All five output enables are high when `master_i`=1 and low when `master_i`=0.
- R8: With `master_i`=0, the phase, line, frame and polarity outputs stay low whatever `duty_i` and `fdiv_i` do.
- R9: `scan_cl_o` and `scan_pol_o` carry the block's own line clock and polarity when `master_i`=1, and follow `cl_i` and `pol_i` when `master_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base oscillator clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| master_i | input | 1 | 1: timing owner, 0: follower |
| fdiv_i | input | 1 | 1: divide the base clock by two first |
| duty_i | input | 2 | Duty code selecting the lines per frame |
| cl_i | input | 1 | Line clock from the external owner |
| pol_i | input | 1 | Polarity from the external owner |
| ph1_o | output | 1 | Column clock phase 1 |
| ph1_oe_o | output | 1 | Enable for phase 1 pad |
| ph2_o | output | 1 | Column clock phase 2 |
| ph2_oe_o | output | 1 | Enable for phase 2 pad |
| line_o | output | 1 | Line clock |
| line_oe_o | output | 1 | Enable for line clock pad |
| frame_o | output | 1 | Frame-start marker |
| frame_oe_o | output | 1 | Enable for frame marker pad |
| pol_o | output | 1 | Frame polarity |
| pol_oe_o | output | 1 | Enable for polarity pad |
| scan_cl_o | output | 1 | Line clock used by the local row scan |
| scan_pol_o | output | 1 | Polarity used by the local row scan |

## Verification
The bench targets the frame wrap for each of the four duty codes. A wrong line length or row limit there shifts the frame marker off line 0 and moves the polarity toggle. It also runs both divide settings, because a missing pre-divide doubles every phase rate and shortens the frame. The reset cycle is checked, since a design that starts at the wrong phase or with polarity high is off by a whole phase or frame from then on. In follower mode the duty and divide inputs are changed, and the checks confirm that no output leaks out and that the scan outputs follow the external line clock and polarity.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

   // Lines per frame for each duty code; the code order is decoded by the board.
   typedef enum logic [1:0] {
      DUTY_48  = 2'b00,
      DUTY_64  = 2'b01,
      DUTY_96  = 2'b10,
      DUTY_128 = 2'b11
   } duty_e;

   // Common multiple of every row count: frame length must be a multiple of it.
   localparam int ROW_LCM  = 384;
   localparam int MAX_ROWS = 128;
   localparam int MIN_ROWS = 48;

   function automatic int rows_of(input logic [1:0] code);
      case (code)
         DUTY_128: return 128;
         DUTY_96:  return 96;
         DUTY_64:  return 64;
         default:  return 48;
      endcase
   endfunction

   typedef struct packed {
      logic ph1;
      logic ph2;
      logic line;
      logic frame;
      logic pol;
   } tim_s;

endpackage

// File: rtl/lcd_clk_phase.sv
module lcd_clk_phase #(
   parameter bit PRE_DIV_EN = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic fdiv_i,
   output logic ph_o,
   output logic clk2_end_o
);

   logic tick;
   logic ph_q;

   generate
      if (PRE_DIV_EN) begin : g_prediv
         logic pre_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni || !run_i || !fdiv_i) pre_q <= 1'b0;
            else                              pre_q <= ~pre_q;
         end
         assign tick = fdiv_i ? pre_q : 1'b1;
      end else begin : g_nodiv
         logic unused_fdiv;
         assign unused_fdiv = fdiv_i;
         assign tick = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !run_i) ph_q <= 1'b0;
      else if (tick)         ph_q <= ~ph_q;
   end

   assign ph_o       = ph_q;
   assign clk2_end_o = run_i & tick & ph_q;

endmodule

// File: rtl/lcd_line_ctr.sv
module lcd_line_ctr #(
   parameter int FRAME_CLK2 = 3072,
   parameter int LW         = $clog2(FRAME_CLK2 / 48)
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       run_i,
   input  logic       step_i,
   input  logic [1:0] duty_i,
   output logic       line_o,
   output logic       line_end_o
);
   import lcd_scan_pkg::*;

   localparam int LEN_128 = FRAME_CLK2 / 128;
   localparam int LEN_96  = FRAME_CLK2 / 96;
   localparam int LEN_64  = FRAME_CLK2 / 64;
   localparam int LEN_48  = FRAME_CLK2 / 48;

   logic [LW-1:0] lcnt_q;
   logic [LW-1:0] len_m1;
   logic [LW-1:0] half;
   logic          at_end;

   always_comb begin
      case (duty_i)
         DUTY_128: begin len_m1 = LW'(LEN_128 - 1); half = LW'(LEN_128 / 2); end
         DUTY_96:  begin len_m1 = LW'(LEN_96 - 1);  half = LW'(LEN_96 / 2);  end
         DUTY_64:  begin len_m1 = LW'(LEN_64 - 1);  half = LW'(LEN_64 / 2);  end
         default:  begin len_m1 = LW'(LEN_48 - 1);  half = LW'(LEN_48 / 2);  end
      endcase
   end

   assign at_end = (lcnt_q >= len_m1);

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !run_i) lcnt_q <= '0;
      else if (step_i)       lcnt_q <= at_end ? '0 : lcnt_q + 1'b1;
   end

   assign line_o     = run_i & (lcnt_q < half);
   assign line_end_o = step_i & at_end;

endmodule

// File: rtl/lcd_frame_ctr.sv
module lcd_frame_ctr #(
   parameter int RW = 7
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       run_i,
   input  logic       step_i,
   input  logic [1:0] duty_i,
   output logic       frame_o,
   output logic       pol_o
);
   import lcd_scan_pkg::*;

   logic [RW-1:0] row_q;
   logic [RW-1:0] last_row;
   logic          wrap;
   logic          pol_q;

   assign last_row = RW'(rows_of(duty_i) - 1);
   assign wrap     = step_i & (row_q >= last_row);

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !run_i) begin
         row_q <= '0;
         pol_q <= 1'b0;
      end else if (step_i) begin
         row_q <= wrap ? '0 : row_q + 1'b1;
         if (wrap) pol_q <= ~pol_q;
      end
   end

   assign frame_o = run_i & (row_q == '0);
   assign pol_o   = pol_q;

endmodule

// File: rtl/lcd_port_mux.sv
module lcd_port_mux
   import lcd_scan_pkg::*;
(
   input  logic master_i,
   input  tim_s own_i,
   input  logic cl_i,
   input  logic pol_i,
   output tim_s pad_o,
   output tim_s oe_o,
   output logic scan_cl_o,
   output logic scan_pol_o
);

   always_comb begin
      pad_o      = master_i ? own_i : '0;
      oe_o       = master_i ? '1 : '0;
      scan_cl_o  = master_i ? own_i.line : cl_i;
      scan_pol_o = master_i ? own_i.pol  : pol_i;
   end

endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing #(
   parameter int FRAME_CLK2 = 3072,
   parameter bit PRE_DIV_EN = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       master_i,
   input  logic       fdiv_i,
   input  logic [1:0] duty_i,
   input  logic       cl_i,
   input  logic       pol_i,
   output logic       ph1_o,
   output logic       ph1_oe_o,
   output logic       ph2_o,
   output logic       ph2_oe_o,
   output logic       line_o,
   output logic       line_oe_o,
   output logic       frame_o,
   output logic       frame_oe_o,
   output logic       pol_o,
   output logic       pol_oe_o,
   output logic       scan_cl_o,
   output logic       scan_pol_o
);
   import lcd_scan_pkg::*;

   localparam int LW = $clog2(FRAME_CLK2 / MIN_ROWS);
   localparam int RW = $clog2(MAX_ROWS);

   initial begin
      assert (FRAME_CLK2 >= ROW_LCM && FRAME_CLK2 % ROW_LCM == 0)
         else $error("FRAME_CLK2 must be a positive multiple of %0d", ROW_LCM);
      assert ((FRAME_CLK2 / MAX_ROWS) % 2 == 0)
         else $error("shortest line must have an even length");
   end

   logic ph;
   logic clk2_end;
   logic line_end;
   tim_s own;
   tim_s pad;
   tim_s oe;

   lcd_clk_phase #(.PRE_DIV_EN(PRE_DIV_EN)) u_phase (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (master_i),
      .fdiv_i    (fdiv_i),
      .ph_o      (ph),
      .clk2_end_o(clk2_end)
   );

   lcd_line_ctr #(.FRAME_CLK2(FRAME_CLK2), .LW(LW)) u_line (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (master_i),
      .step_i    (clk2_end),
      .duty_i    (duty_i),
      .line_o    (own.line),
      .line_end_o(line_end)
   );

   lcd_frame_ctr #(.RW(RW)) u_frame (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (master_i),
      .step_i (line_end),
      .duty_i (duty_i),
      .frame_o(own.frame),
      .pol_o  (own.pol)
   );

   assign own.ph1 = master_i & ~ph;
   assign own.ph2 = master_i & ph;

   lcd_port_mux u_mux (
      .master_i  (master_i),
      .own_i     (own),
      .cl_i      (cl_i),
      .pol_i     (pol_i),
      .pad_o     (pad),
      .oe_o      (oe),
      .scan_cl_o (scan_cl_o),
      .scan_pol_o(scan_pol_o)
   );

   assign ph1_o      = pad.ph1;
   assign ph2_o      = pad.ph2;
   assign line_o     = pad.line;
   assign frame_o    = pad.frame;
   assign pol_o      = pad.pol;
   assign ph1_oe_o   = oe.ph1;
   assign ph2_oe_o   = oe.ph2;
   assign line_oe_o  = oe.line;
   assign frame_oe_o = oe.frame;
   assign pol_oe_o   = oe.pol;

endmodule

// File: rtl/lcd_scan_timing_chk.sv
module lcd_scan_timing_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       master_i,
   input logic       fdiv_i,
   input logic [1:0] duty_i,
   input logic       cl_i,
   input logic       pol_i,
   input logic       ph1_o,
   input logic       ph1_oe_o,
   input logic       ph2_o,
   input logic       ph2_oe_o,
   input logic       line_o,
   input logic       line_oe_o,
   input logic       frame_o,
   input logic       frame_oe_o,
   input logic       pol_o,
   input logic       pol_oe_o,
   input logic       scan_cl_o,
   input logic       scan_pol_o
);

   logic unused_duty;
   assign unused_duty = ^duty_i;

   // R3
   no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ph1_o && ph2_o));

   // R2
   clk2_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (master_i && $past(master_i) && !fdiv_i && !$past(fdiv_i) && $past(rst_ni))
      |-> (ph2_o != $past(ph2_o)));

   // R6
   pol_at_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (master_i && $past(master_i) && $past(rst_ni) && (pol_o != $past(pol_o)))
      |-> $rose(frame_o));

   // R4
   frame_on_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $rose(frame_o)) |-> line_o);

   // R7
   oe_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      master_i |-> (ph1_oe_o && ph2_oe_o && line_oe_o && frame_oe_o && pol_oe_o));

   // R8
   slave_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !master_i |-> (!ph1_o && !ph2_o && !line_o && !frame_o && !pol_o &&
                     !ph1_oe_o && !ph2_oe_o && !line_oe_o && !frame_oe_o && !pol_oe_o));

   // R9
   scan_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !master_i |-> (scan_cl_o == cl_i && scan_pol_o == pol_i));

endmodule

bind lcd_scan_timing lcd_scan_timing_chk u_chk (.*);

// File: tb/lcd_scan_timing_tb.sv
module lcd_scan_timing_tb;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n  = 1'b0;
   logic       master = 1'b1;
   logic       fdiv   = 1'b0;
   logic [1:0] duty   = 2'b00;
   logic       cl_in  = 1'b0;
   logic       pol_in = 1'b0;
   logic ph1, ph1_oe, ph2, ph2_oe, line, line_oe, frame, frame_oe, pol, pol_oe;
   logic scl, spol;

   lcd_scan_timing u_dut (
      .clk_i(clk), .rst_ni(rst_n), .master_i(master), .fdiv_i(fdiv), .duty_i(duty),
      .cl_i(cl_in), .pol_i(pol_in),
      .ph1_o(ph1), .ph1_oe_o(ph1_oe), .ph2_o(ph2), .ph2_oe_o(ph2_oe),
      .line_o(line), .line_oe_o(line_oe), .frame_o(frame), .frame_oe_o(frame_oe),
      .pol_o(pol), .pol_oe_o(pol_oe), .scan_cl_o(scl), .scan_pol_o(spol)
   );

   typedef struct {
      int t;
      bit mst;
      bit ph1, ph2, line, frame, pol, scl, spol;
   } exp_t;

   exp_t q[$];
   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 0;

   task automatic chk(input string tag, input int t, input logic got, input bit exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s t=%0d actual=%0b expected=%0b", tag, t, got, exp);
      end
   endtask

   function automatic int rows_for(input logic [1:0] c);
      case (c)
         2'b11: return 128;
         2'b10: return 96;
         2'b01: return 64;
         default: return 48;
      endcase
   endfunction

   // driver: configures, resets, then pushes one expected item per cycle
   task automatic run_cfg(input bit m, input bit fs, input logic [1:0] du, input int n);
      @(negedge clk);
      rst_n = 1'b0; master = m; fdiv = fs; duty = du; cl_in = 1'b0; pol_in = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int t = 0; t < n; t++) begin
         exp_t e;
         int d, k, rows, len, lc;
         e.t = t;
         e.mst = m;
         if (m) begin
            d    = fs ? 2 : 1;
            k    = t / (2 * d);
            rows = rows_for(du);
            len  = 3072 / rows;
            lc   = k % len;
            e.ph1   = ((t / d) % 2) == 0;
            e.ph2   = !e.ph1;
            e.line  = lc < len / 2;
            e.frame = ((k / len) % rows) == 0;
            e.pol   = ((k / (len * rows)) % 2) == 1;
            e.scl   = e.line;
            e.spol  = e.pol;
         end else begin
            cl_in  = ((t >> 3) & 1) == 1;
            pol_in = ((t >> 6) & 1) == 1;
            duty   = 2'(t);
            fdiv   = ((t >> 2) & 1) == 1;
            e.ph1 = 0; e.ph2 = 0; e.line = 0; e.frame = 0; e.pol = 0;
            e.scl  = cl_in;
            e.spol = pol_in;
         end
         q.push_back(e);
         @(negedge clk);
      end
   endtask

   // monitor: pops expected items and compares them with the ports
   always @(negedge clk) begin
      exp_t e;
      #1;
      while (q.size() > 0) begin
         e = q.pop_front();
         if (e.mst) begin
            if (e.t == 0) begin
               chk("R1 ph1", e.t, ph1, e.ph1);
               chk("R1 ph2", e.t, ph2, e.ph2);
               chk("R1 line", e.t, line, e.line);
               chk("R1 frame", e.t, frame, e.frame);
               chk("R1 pol", e.t, pol, e.pol);
            end else begin
               chk("R2 ph1", e.t, ph1, e.ph1);
               chk("R2 ph2", e.t, ph2, e.ph2);
               chk("R5 line", e.t, line, e.line);
               chk("R4 frame", e.t, frame, e.frame);
               chk("R6 pol", e.t, pol, e.pol);
            end
            chk("R3 overlap", e.t, ph1 & ph2, 1'b0);
            chk("R7 oe", e.t, ph1_oe & ph2_oe & line_oe & frame_oe & pol_oe, 1'b1);
         end else begin
            chk("R8 outputs", e.t, ph1 | ph2 | line | frame | pol, 1'b0);
            chk("R7 oe", e.t, ph1_oe | ph2_oe | line_oe | frame_oe | pol_oe, 1'b0);
         end
         chk("R9 scan_cl", e.t, scl, e.scl);
         chk("R9 scan_pol", e.t, spol, e.spol);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 200000 && !done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      run_cfg(1'b1, 1'b0, 2'b01, 15000);   // R4 R5 R6: 64 lines, two polarity flips
      run_cfg(1'b1, 1'b1, 2'b11, 13000);   // R2 pre-divide, 128 lines
      run_cfg(1'b1, 1'b0, 2'b00, 6500);    // 48 lines
      run_cfg(1'b1, 1'b0, 2'b10, 6500);    // 96 lines
      run_cfg(1'b0, 1'b0, 2'b11, 400);     // R8 R9 follower, duty and divide ignored
      run_cfg(1'b1, 1'b1, 2'b00, 3000);    // R1 again after follower mode
      @(negedge clk);
      #2;
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule